// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block decides when a multi-phase buck converter may run and walks it through a fixed, phased start-up. It counts pulses of a phase-clock strobe, one pulse for each switching cycle. From that count it sets three things: the mode of the PWM outputs (high-impedance, forced low or active), an enable for the reference ramp, and a power-good flag.

The converter runs only while three conditions hold together: supply power-on reset has completed, the external enable is above its threshold, and the voltage-identification code is not the all-ones sleep code. When all three hold, start-up begins at once. The PWM pins float for the first stretch of cycles while the reference is held off. The pins are then clamped low for a fixed interval while the reference begins to rise. After that the pins go active and the duty cycle ramps up from zero. Power-good is held back until a long count has expired and the output is reported inside its window. If any enable condition drops, the block returns to shutdown.

The analog comparators, the oscillator, the overvoltage window detector and the PWM generator lie outside this block and connect to it through its ports.

Top module: `ss_sequencer`

## Requirements
- R1: The block is enabled only while `por_ok` = 1, `en_ok` = 1 and `vid` != 5'b11111. While any of these is false, phase ticks have no effect and the outputs stay at `pwm_mode` = 2'b00, `ramp_en` = 0, `pwr_good` = 0.
- R2: While `rst` is high and after it is released with the block disabled, `pwm_mode` = 2'b00 (high-impedance), `ramp_en` = 0 and `pwr_good` = 0.
- R3: Once enabled, the block stays in `pwm_mode` = 2'b00 with `ramp_en` = 0 until 32 phase ticks have been counted.
- R4: After 32 ticks and until 182 ticks (a clamp interval of exactly 150 cycles), `pwm_mode` = 2'b01 (forced low) and `ramp_en` = 1.
- R5: From 182 counted ticks on, which is the 183rd switching cycle, `pwm_mode` = 2'b10 (active) and `ramp_en` = 1.
- R6: The cycle count advances only on a clock edge where `phase_tick` = 1. With no tick, the outputs hold.
- R7: `pwr_good` = 1 only when at least 2048 ticks have been counted and `vout_ok` = 1. It follows `vout_ok` once the count has been reached.
- R8: The count saturates at 2048. Further ticks leave the block active, with power-good still granted.
- R9: Losing any enable condition clears the count. On the next clock edge it returns `pwm_mode` to 2'b00 and drops `ramp_en` and `pwr_good`. A later re-enable restarts the sequence from its first cycle.
- R10: Counting begins with the first tick after the clock edge on which the enable conditions are first seen true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply power-on reset complete |
| en_ok | input | 1 | External enable above threshold |
| vid | input | 5 | Voltage-identification code |
| phase_tick | input | 1 | One-clock strobe per switching cycle |
| vout_ok | input | 1 | Output voltage inside its window |
| pwm_mode | output | 2 | 00 high-impedance, 01 forced low, 10 active |
| ramp_en | output | 1 | Reference ramp enable |
| pwr_good | output | 1 | Power-good |

## Verification
The bench builds the block with its default parameters: 32 float cycles, a 150-cycle clamp and a 2048-cycle power-good count. At these values the exact boundaries at ticks 32, 182 and 2048 are reached and checked on both sides. A tick every other clock keeps the full 2048-cycle sequence short enough to run several times, so the bench also covers saturation, shutdown at each stage and a restart from zero.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        MODE_HIZ    = 2'b00,
        MODE_LOW    = 2'b01,
        MODE_ACTIVE = 2'b10
    } pwm_mode_e;

    typedef struct packed {
        pwm_mode_e mode;
        logic      ramp;
        logic      good;
    } seq_out_t;

    function automatic logic vid_is_sleep(input logic [4:0] code);
        return &code;
    endfunction

endpackage

// File: rtl/ss_enable_qual.sv
module ss_enable_qual (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_ok,
    input  logic       en_ok,
    input  logic [4:0] vid,
    output logic       en_now,
    output logic       run_q
);
    import ss_pkg::*;

    assign en_now = por_ok && en_ok && !vid_is_sleep(vid);

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en_now;
    end

    // R1: the sleep code always leaves the block stopped one edge later
    p_sleep_stops_r1: assert property (@(posedge clk) disable iff (rst)
        (vid == 5'b11111) |=> !run_q);

endmodule

// File: rtl/ss_cycle_counter.sv
module ss_cycle_counter #(
    parameter int LIMIT = 2048,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_now,
    input  logic          run_q,
    input  logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !en_now)                    count <= '0;
        else if (run_q && tick && count != SAT) count <= count + 1'b1;
    end

    // R8: once saturated and still enabled, the count holds
    p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
        (count == SAT && en_now) |=> count == SAT);

    // R6: without a tick the count does not move while enabled
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick && en_now) |=> $stable(count));

endmodule

// File: rtl/ss_phase_decode.sv
module ss_phase_decode #(
    parameter int HIZ_CYCLES   = 32,
    parameter int CLAMP_CYCLES = 150,
    parameter int PG_CYCLES    = 2048,
    parameter int CW           = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_q,
    input  logic [CW-1:0]     count,
    input  logic              vout_ok,
    output ss_pkg::seq_out_t  out
);
    import ss_pkg::*;

    localparam logic [CW-1:0] LOW_AT = CW'(HIZ_CYCLES);
    localparam logic [CW-1:0] ACT_AT = CW'(HIZ_CYCLES + CLAMP_CYCLES);
    localparam logic [CW-1:0] PG_AT  = CW'(PG_CYCLES);

    always_comb begin
        out = '{mode: MODE_HIZ, ramp: 1'b0, good: 1'b0};
        if (run_q) begin
            if (count >= ACT_AT)      out.mode = MODE_ACTIVE;
            else if (count >= LOW_AT) out.mode = MODE_LOW;
            out.ramp = (count >= LOW_AT);
            out.good = (count >= PG_AT) && vout_ok;
        end
    end

    // R7: power-good implies the outputs are switching
    p_good_needs_active_r7: assert property (@(posedge clk) disable iff (rst)
        out.good |-> out.mode == MODE_ACTIVE);

    // R9: leaving active mode only goes back to high-impedance
    p_active_exit_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(out.mode) == MODE_ACTIVE && out.mode != MODE_ACTIVE) |-> out.mode == MODE_HIZ);

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer #(
    parameter int HIZ_CYCLES   = 32,
    parameter int CLAMP_CYCLES = 150,
    parameter int PG_CYCLES    = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_ok,
    input  logic       en_ok,
    input  logic [4:0] vid,
    input  logic       phase_tick,
    input  logic       vout_ok,
    output logic [1:0] pwm_mode,
    output logic       ramp_en,
    output logic       pwr_good
);
    import ss_pkg::*;

    localparam int CW = $clog2(PG_CYCLES + 1);

    logic          en_now;
    logic          run_q;
    logic [CW-1:0] count;
    seq_out_t      dec;

    ss_enable_qual u_qual (
        .clk(clk), .rst(rst), .por_ok(por_ok), .en_ok(en_ok), .vid(vid),
        .en_now(en_now), .run_q(run_q)
    );

    ss_cycle_counter #(.LIMIT(PG_CYCLES), .CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .en_now(en_now), .run_q(run_q),
        .tick(phase_tick), .count(count)
    );

    ss_phase_decode #(
        .HIZ_CYCLES(HIZ_CYCLES), .CLAMP_CYCLES(CLAMP_CYCLES),
        .PG_CYCLES(PG_CYCLES), .CW(CW)
    ) u_dec (
        .clk(clk), .rst(rst), .run_q(run_q), .count(count),
        .vout_ok(vout_ok), .out(dec)
    );

    assign pwm_mode = dec.mode;
    assign ramp_en  = dec.ramp;
    assign pwr_good = dec.good;

    // R9: a lost enable condition forces shutdown outputs one edge later
    p_shutdown_r9: assert property (@(posedge clk) disable iff (rst)
        !(por_ok && en_ok && vid != 5'b11111) |=> (pwm_mode == 2'b00 && !ramp_en && !pwr_good));

    // R2: reset leaves the outputs quiet
    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> (pwm_mode == 2'b00 && !pwr_good));

endmodule

// File: tb/sim_ss_sequencer.sv
module sim_ss_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_ok = 1'b0, en_ok = 1'b0, phase_tick = 1'b0, vout_ok = 1'b0;
    logic [4:0] vid = 5'h0A;
    logic [1:0] pwm_mode;
    logic       ramp_en, pwr_good;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ss_sequencer u0 (
        .clk(clk), .rst(rst), .por_ok(por_ok), .en_ok(en_ok), .vid(vid),
        .phase_tick(phase_tick), .vout_ok(vout_ok),
        .pwm_mode(pwm_mode), .ramp_en(ramp_en), .pwr_good(pwr_good)
    );

    task automatic check(input string req, input logic [1:0] m, input logic r, input logic g);
        n_run++;
        if (pwm_mode !== m || ramp_en !== r || pwr_good !== g) begin
            n_fail++;
            $display("FAIL %s: got mode=%b ramp=%b pg=%b, expected mode=%b ramp=%b pg=%b",
                     req, pwm_mode, ramp_en, pwr_good, m, r, g);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) phase_tick = 1'b1;
            @(negedge clk) phase_tick = 1'b0;
        end
    endtask

    task automatic enable_all();
        @(negedge clk) begin por_ok = 1'b1; en_ok = 1'b1; vid = 5'h0A; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk) check("R2 in reset", 2'b00, 1'b0, 1'b0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk) check("R2 after reset", 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_qualify();
        @(negedge clk) begin por_ok = 1'b0; en_ok = 1'b1; vid = 5'h0A; end
        ticks(40); check("R1 no por", 2'b00, 1'b0, 1'b0);
        @(negedge clk) begin por_ok = 1'b1; en_ok = 1'b0; end
        ticks(40); check("R1 no enable", 2'b00, 1'b0, 1'b0);
        @(negedge clk) begin en_ok = 1'b1; vid = 5'b11111; end
        ticks(40); check("R1 sleep code", 2'b00, 1'b0, 1'b0);
        @(negedge clk) begin por_ok = 1'b0; en_ok = 1'b0; vid = 5'h0A; end
        @(negedge clk);
    endtask

    task automatic t_startup();
        enable_all();
        ticks(31); check("R3 tick 31", 2'b00, 1'b0, 1'b0);
        ticks(1);  check("R4 tick 32", 2'b01, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check("R6 no tick hold", 2'b01, 1'b1, 1'b0);
        ticks(149); check("R4 tick 181", 2'b01, 1'b1, 1'b0);
        ticks(1);   check("R5 tick 182", 2'b10, 1'b1, 1'b0);
        vout_ok = 1'b1;
        ticks(2047 - 182); check("R7 tick 2047", 2'b10, 1'b1, 1'b0);
        ticks(1);  check("R7 tick 2048", 2'b10, 1'b1, 1'b1);
        vout_ok = 1'b0; #1;
        check("R7 window low", 2'b10, 1'b1, 1'b0);
        vout_ok = 1'b1;
        ticks(10); check("R8 saturated", 2'b10, 1'b1, 1'b1);
    endtask

    task automatic t_shutdown_restart();
        @(negedge clk) vid = 5'b11111;
        @(negedge clk) check("R9 shutdown next edge", 2'b00, 1'b0, 1'b0);
        @(negedge clk) vid = 5'h12;
        ticks(1); check("R10 restart tick 1", 2'b00, 1'b0, 1'b0);
        ticks(31); check("R9 restart tick 32", 2'b01, 1'b1, 1'b0);
        @(negedge clk) por_ok = 1'b0;
        @(negedge clk) check("R9 por loss", 2'b00, 1'b0, 1'b0);
        // R10: first tick arrives on the same edge that sees enable
        @(negedge clk) begin por_ok = 1'b1; phase_tick = 1'b1; end
        @(negedge clk) phase_tick = 1'b0;
        ticks(31); check("R10 first tick not counted", 2'b00, 1'b0, 1'b0);
        ticks(1);  check("R10 count from next tick", 2'b01, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_qualify();
        t_startup();
        t_shutdown_restart();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule